// File: doc/BRIEF.md
# Gated-Input Serial-to-Parallel Shift Register

This block is an eight-stage shift register that takes one serial bit per rising clock edge and presents every stage on a parallel output bus. The bit that enters is the logical AND of two input pins. Either pin can carry the data stream while the other is held high as a shift enable. When either pin is low, a zero enters.

An active-low clear empties every stage at once, without waiting for a clock edge. While the clear is asserted it overrides the clock. The register does not hold its contents when the enable pin is low. It keeps moving data toward the last stage and fills the first stage with zeros. The last stage drops its bit on each edge, and it can drive the serial input of a following register to make a longer chain.

Top module: `gated_sipo`

## Requirements
- R1: Driving `clr_n` low forces `par_q` to all zeros at once, with no clock edge needed.
- R2: While `clr_n` is low, rising clock edges leave `par_q` at all zeros.
- R3: On each rising edge with `clr_n` high, `par_q[0]` takes the value `din_a & din_b` that was present at that edge.
- R4: On each rising edge with `clr_n` high, every `par_q[i]` for i from 1 to 7 takes the value that `par_q[i-1]` held before the edge. Stage index 0 is the entry end and index 7 is the far end.
- R5: With `din_a` held at 1, the stream on `din_b` appears unchanged in `par_q[0]`, and with `din_b` held at 1 the stream on `din_a` does too.
- R6: When either data pin is 0 at an edge, a 0 enters `par_q[0]`, and the other stages still advance. The register does not hold its contents.
- R7: The bit in `par_q[7]` is discarded at the next edge. Eight edges with a gated-off input leave `par_q` at all zeros.
- R8: After `clr_n` is released, `par_q` stays zero until the next rising edge, and that edge performs the first shift.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; the register shifts on the rising edge |
| clr_n | input | 1 | Asynchronous clear, active low |
| din_a | input | 1 | Serial input pin; ANDed with din_b |
| din_b | input | 1 | Serial input pin; ANDed with din_a |
| par_q | output | 8 | Stage contents; bit 0 is the entry stage, bit 7 the far end |

## Verification
The bench targets the clear. It pulls `clr_n` low in the middle of a clock period while the register holds ones and checks the outputs before any edge arrives. A clear that waited for the clock would leave stale ones visible there. It then releases the clear mid-period and confirms that nothing moves until the next edge, which catches a design that shifts as soon as the clear is released. It also holds one pin low with the other high. A design that froze its contents in that case, instead of shifting in zeros, would keep its old pattern. Finally, it tracks a single one through all eight stages and out of the far end, which exposes reversed bit order and any wrap-around from the last stage back to the first.

// File: rtl/gsr_pkg.sv
// Package: shared sizing for the gated shift register.
// Assumes: the register depth is at least two stages.
package gsr_pkg;
    localparam int unsigned GSR_DEPTH_DEF = 8;
endpackage

// File: rtl/gsr_entry_gate.sv
// Module: gsr_entry_gate
// Forms the bit that enters the first stage from the two input pins.
// Assumes: both pins are synchronous to the register clock.
module gsr_entry_gate (
    input  logic pin_a,
    input  logic pin_b,
    output logic gated_bit
);
    // Either pin low blocks the other pin's data (R6).
    always_comb begin
        gated_bit = pin_a & pin_b;
    end
endmodule

// File: rtl/gsr_stage.sv
// Module: gsr_stage
// One storage cell of the chain, cleared asynchronously.
// Assumes: clr_n is deasserted with enough margin before a clock edge.
module gsr_stage (
    input  logic clk,
    input  logic clr_n,
    input  logic d,
    output logic q
);
    // Capture on the rising edge; the clear overrides the clock (R1, R2).
    always_ff @(posedge clk or negedge clr_n) begin
        if (!clr_n) q <= 1'b0;
        else        q <= d;
    end
endmodule

// File: rtl/gated_sipo.sv
// Module: gated_sipo
// Serial-in, parallel-out shift register whose input is the AND of two pins.
// Bit 0 is the entry stage; data moves toward the last index each edge.
// Assumes: DEPTH >= 2; the far-end bit is discarded on every shift.
module gated_sipo #(
    parameter int unsigned DEPTH = gsr_pkg::GSR_DEPTH_DEF
) (
    input  logic             clk,
    input  logic             clr_n,
    input  logic             din_a,
    input  logic             din_b,
    output logic [DEPTH-1:0] par_q
);
    localparam int unsigned LAST = DEPTH - 1;

    logic             entry_bit;
    logic [DEPTH-1:0] stage_d;

    gsr_entry_gate u_gate (
        .pin_a     (din_a),
        .pin_b     (din_b),
        .gated_bit (entry_bit)
    );

    // Feed each stage from its upstream neighbour, stage 0 from the gate (R3, R4).
    always_comb begin
        stage_d = {par_q[LAST-1:0], entry_bit};
    end

    for (genvar g = 0; g < DEPTH; g++) begin : g_stage
        gsr_stage u_stage (
            .clk   (clk),
            .clr_n (clr_n),
            .d     (stage_d[g]),
            .q     (par_q[g])
        );
    end
endmodule

// File: rtl/gated_sipo_checker.sv
// Module: gated_sipo_checker
// Temporal checks on the gated shift register, bound to every instance.
// Assumes: clr_n never changes exactly on a clock edge.
module gated_sipo_checker #(
    parameter int unsigned DEPTH = 8
) (
    input logic             clk,
    input logic             clr_n,
    input logic             din_a,
    input logic             din_b,
    input logic [DEPTH-1:0] par_q
);
    // Clear holds every stage at zero whenever it is low (R1, R2).
    always @(negedge clk) begin
        if (!clr_n) begin
            assert_clear_zero_R1: assert (par_q == '0)
                else $error("clear did not empty the register");
        end
    end

    assert_entry_bit_R3: assert property (@(posedge clk) disable iff (!clr_n)
        1'b1 |=> par_q[0] == $past(din_a & din_b));

    assert_advance_R4: assert property (@(posedge clk) disable iff (!clr_n)
        1'b1 |=> par_q[DEPTH-1:1] == $past(par_q[DEPTH-2:0]));

    assert_blocked_zero_R6: assert property (@(posedge clk) disable iff (!clr_n)
        !(din_a && din_b) |=> !par_q[0]);
endmodule

bind gated_sipo gated_sipo_checker #(.DEPTH(DEPTH)) u_chk (
    .clk   (clk),
    .clr_n (clr_n),
    .din_a (din_a),
    .din_b (din_b),
    .par_q (par_q)
);

// File: tb/gated_sipo_test.sv
`timescale 1ns/1ps
module gated_sipo_test;
    localparam int N = 8;

    logic         clk = 1'b0;
    logic         clr_n = 1'b0;
    logic         din_a = 1'b0;
    logic         din_b = 1'b0;
    logic [N-1:0] par_q;

    int  n_run = 0;
    int  n_bad = 0;
    bit  mdl[$];   // mdl[0] is the entry stage
    bit  done = 1'b0;

    gated_sipo #(.DEPTH(N)) uut (
        .clk(clk), .clr_n(clr_n), .din_a(din_a), .din_b(din_b), .par_q(par_q)
    );

    always #5 clk = ~clk;

    function automatic logic [N-1:0] mdl_vec();
        logic [N-1:0] v;
        for (int i = 0; i < N; i++) v[i] = mdl[i];
        return v;
    endfunction

    task automatic check(string req, logic [N-1:0] act, logic [N-1:0] exp);
        n_run++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: par_q=%b expected %b", req, act, exp);
        end
    endtask

    task automatic mdl_clear();
        mdl.delete();
        for (int i = 0; i < N; i++) mdl.push_back(1'b0);
    endtask

    // Present the pins, take one edge, update the model, compare.
    task automatic step(bit a, bit b, string req);
        din_a = a;
        din_b = b;
        @(posedge clk);
        #1;
        if (clr_n) begin
            mdl.push_front(a & b);
            void'(mdl.pop_back());
        end
        check(req, par_q, mdl_vec());
    endtask

    initial begin
        logic [7:0] pat;
        mdl_clear();
        #2;
        check("R1 reset", par_q, '0);
        step(1, 1, "R2 edge during clear");
        step(1, 1, "R2 edge during clear");
        #3 clr_n = 1'b1;
        #1 check("R8 release before edge", par_q, '0);
        step(1, 1, "R8 first shift after release");
        step(0, 0, "R3 entry bit");
        // data on B, A as enable
        pat = 8'b1011_0010;
        for (int i = 0; i < 8; i++) step(1, pat[i], "R5 data on din_b");
        // data on A, B as enable
        pat = 8'b0110_1101;
        for (int i = 0; i < 8; i++) step(pat[i], 1, "R5 data on din_a");
        // enable low: zeros shift in, register keeps moving
        step(1, 0, "R6 blocked by din_b");
        step(0, 1, "R6 blocked by din_a");
        for (int i = 0; i < 6; i++) step(1, 0, "R6 zeros advance");
        check("R7 flushed after eight blocked edges", par_q, '0);
        // single one walks the chain and leaves
        step(1, 1, "R4 lone one enters");
        for (int i = 1; i < N; i++) step(0, 1, "R4 lone one advances");
        check("R4 lone one at far end", par_q, 8'b1000_0000);
        step(0, 1, "R7 far-end bit discarded");
        check("R7 nothing wraps", par_q, '0);
        // fill with ones, clear mid-period
        for (int i = 0; i < N; i++) step(1, 1, "R3 fill ones");
        #2 clr_n = 1'b0;
        #1 check("R1 clear mid-cycle without edge", par_q, '0);
        mdl_clear();
        step(1, 1, "R2 edge held by clear");
        #3 clr_n = 1'b1;
        #1 check("R8 still zero after release", par_q, '0);
        step(1, 1, "R8 shift resumes");
        step(1, 0, "R4 after resume");
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_bad);
        $finish;
    end

    initial begin
        #1_000_000;
        if (!done) begin
            n_run++;
            n_bad++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_bad);
            $finish;
        end
    end
endmodule